// File: doc/BRIEF.md
# Indirect PCI Configuration and IO Access Port

This block lets a CPU reach PCI configuration space and PCI IO space through three small register windows. Software first loads a shared 32-bit pointer register. A following access to the configuration window or to the IO window is then turned into one request on a simple downstream request/response interface. The pointer with its two low bits cleared forms the base of that request, and the byte offset inside the window forms the low bits. The block checks the access size against the byte offset, puts the data into the byte order the target space expects, and holds the CPU access until the downstream side answers.

On the CPU side the requester raises `cpu_req_i` with its command and keeps it there until `cpu_ack_o` is high for one cycle. Only one downstream request is open at a time. Data on both sides is right-justified. On the downstream side, bits [7:0] carry the byte at the lowest address. Size codes are 0 for one byte, 1 for two bytes and 2 for four bytes. Code 3 is illegal. The pointer register sits at offset 0x0, the configuration window at 0x4 to 0x7 and the IO window at 0x8 to 0xB. These are the parameter defaults.

Top module: `pci_indirect_port`

## Requirements
- R1: The pointer register accepts only a 4-byte access at its offset 0. A read of it returns exactly the last accepted write, including bits [1:0]. Its reset value is 0.
- R2: A configuration-window access at byte offset k sends a request with `ds_io_o`=0 to the address formed from pointer[31:2] and k in bits [1:0]. No enable bit of the pointer is checked.
- R3: An IO-window access at byte offset k sends a request with `ds_io_o`=1 to the address (pointer with bits [1:0] cleared, plus k), truncated to 16 bits. Address bits [31:16] are zero.
- R4: The IO window accepts 1, 2 or 4 bytes at offset 0, 1 or 2 bytes at offset 2, and only 1 byte at offsets 1 and 3.
- R5: The configuration window accepts 1, 2 or 4 bytes whenever k plus the size is at most 4. Size code 3 and offsets outside the three windows are rejected.
- R6: Configuration data passes through unswapped and masked to the access size. IO data of 2 or 4 bytes is byte-reversed within the access size in both directions.
- R7: The downstream error flag is returned as `cpu_err_o` of the CPU access. Any error response reads as zero.
- R8: A rejected access issues no downstream request, answers with `cpu_err_o`=1 and read data zero, and leaves the pointer unchanged.
- R9: Each accepted window access issues exactly one downstream request. That request holds steady until `ds_ack_i`. `cpu_ack_o` is a one-cycle pulse that comes only after the downstream response.
- R10: After reset no downstream request and no CPU acknowledge are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU access request, held until acknowledged |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_off_i | input | OFF_W | Byte offset inside the block |
| cpu_size_i | input | 2 | Access size code (0:1B, 1:2B, 2:4B, 3:illegal) |
| cpu_wdata_i | input | 32 | Right-justified write data |
| cpu_ack_o | output | 1 | One-cycle completion pulse |
| cpu_err_o | output | 1 | Error status of the completed access |
| cpu_rdata_o | output | 32 | Right-justified read data, valid with ack |
| ds_req_o | output | 1 | Downstream request, held until ds_ack_i |
| ds_io_o | output | 1 | 1 = IO space, 0 = configuration space |
| ds_we_o | output | 1 | Downstream write |
| ds_addr_o | output | 32 | Downstream address |
| ds_size_o | output | 2 | Downstream size code |
| ds_wdata_o | output | 32 | Downstream write data, low byte at lowest address |
| ds_ack_i | input | 1 | Downstream response strobe |
| ds_err_i | input | 1 | Downstream error, valid with ds_ack_i |
| ds_rdata_i | input | 32 | Downstream read data, valid with ds_ack_i |

## Verification
The assertions assume a well-behaved requester. It holds `cpu_req_i` and its command steady until the acknowledge and drops the request in the acknowledge cycle. They also assume a responder that raises `ds_ack_i` only while `ds_req_o` is high, and for a single cycle. The bench drives both sides from one access task that follows these rules exactly. It releases the request at the falling edge where it sees the acknowledge, and pulses the downstream response once after a chosen latency. Within these limits the bench varies the offsets, sizes, response latency and downstream error.

// File: rtl/pcib_pkg.sv
package pcib_pkg;
  localparam logic [1:0] SZ_1   = 2'd0;
  localparam logic [1:0] SZ_2   = 2'd1;
  localparam logic [1:0] SZ_4   = 2'd2;
  localparam logic [1:0] SZ_BAD = 2'd3;

  typedef enum logic [1:0] {TGT_NONE, TGT_PTR, TGT_CFG, TGT_IO} tgt_e;
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RESP} state_e;

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_1:    size_mask = 32'h0000_00ff;
      SZ_2:    size_mask = 32'h0000_ffff;
      default: size_mask = 32'hffff_ffff;
    endcase
  endfunction

  // reverse bytes inside the access size, result right-justified
  function automatic logic [31:0] swap_sz(input logic [31:0] d, input logic [1:0] sz);
    logic [31:0] r;
    r = '0;
    case (sz)
      SZ_1:    r[7:0] = d[7:0];
      SZ_2:    r[15:0] = {d[7:0], d[15:8]};
      default: for (int i = 0; i < 4; i++) r[8*i +: 8] = d[8*(3-i) +: 8];
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pcib_decode.sv
module pcib_decode
  import pcib_pkg::*;
#(
  parameter int OFF_W   = 4,
  parameter int PTR_OFF = 0,
  parameter int CFG_OFF = 4,
  parameter int IO_OFF  = 8
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  output tgt_e             tgt_o,
  output logic [1:0]       k_o
);
  logic [OFF_W-1:0] base;
  logic [2:0]       nbytes;
  logic             cfg_ok, io_ok, ptr_ok;

  assign base = {off_i[OFF_W-1:2], 2'b00};
  assign k_o  = off_i[1:0];

  always_comb begin
    case (size_i)
      SZ_1:    nbytes = 3'd1;
      SZ_2:    nbytes = 3'd2;
      default: nbytes = 3'd4;
    endcase
  end

  assign ptr_ok = (size_i == SZ_4) && (k_o == 2'd0);
  assign cfg_ok = (size_i != SZ_BAD) && (({1'b0, k_o} + nbytes) <= 3'd4);

  always_comb begin
    case (size_i)
      SZ_1:    io_ok = 1'b1;
      SZ_2:    io_ok = (k_o[0] == 1'b0);
      SZ_4:    io_ok = (k_o == 2'd0);
      default: io_ok = 1'b0;
    endcase
  end

  always_comb begin
    tgt_o = TGT_NONE;
    if (base == OFF_W'(PTR_OFF) && ptr_ok)      tgt_o = TGT_PTR;
    else if (base == OFF_W'(CFG_OFF) && cfg_ok) tgt_o = TGT_CFG;
    else if (base == OFF_W'(IO_OFF) && io_ok)   tgt_o = TGT_IO;
  end
endmodule

// File: rtl/pcib_ptr_reg.sv
module pcib_ptr_reg (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] raw_o,
  output logic [31:0] work_o
);
  logic [31:0] raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   raw_q <= '0;
    else if (we_i) raw_q <= wdata_i;
  end

  assign raw_o  = raw_q;
  assign work_o = {raw_q[31:2], 2'b00};
endmodule

// File: rtl/pcib_ctrl.sv
module pcib_ctrl
  import pcib_pkg::*;
#(
  parameter int IO_AW = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cpu_req_i,
  input  logic        cpu_we_i,
  input  logic [1:0]  cpu_size_i,
  input  logic [31:0] cpu_wdata_i,
  input  tgt_e        tgt_i,
  input  logic [1:0]  k_i,
  input  logic [31:0] raw_i,
  input  logic [31:0] work_i,
  output logic        ptr_we_o,
  output logic        cpu_ack_o,
  output logic        cpu_err_o,
  output logic [31:0] cpu_rdata_o,
  output logic        ds_req_o,
  output logic        ds_io_o,
  output logic        ds_we_o,
  output logic [31:0] ds_addr_o,
  output logic [1:0]  ds_size_o,
  output logic [31:0] ds_wdata_o,
  input  logic        ds_ack_i,
  input  logic        ds_err_i,
  input  logic [31:0] ds_rdata_i
);
  state_e      state_q;
  logic        req_q, io_q, we_q, err_q;
  logic [1:0]  size_q;
  logic [31:0] addr_q, wdata_q, rdata_q;
  logic        accept;
  logic [IO_AW-1:0] io_addr;
  logic [31:0] rd_fmt;

  assign accept   = (state_q == S_IDLE) && cpu_req_i;
  assign ptr_we_o = accept && (tgt_i == TGT_PTR) && cpu_we_i;
  assign io_addr  = work_i[IO_AW-1:0] + IO_AW'(k_i);
  assign rd_fmt   = io_q ? swap_sz(ds_rdata_i, size_q) : (ds_rdata_i & size_mask(size_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      req_q   <= 1'b0;
      io_q    <= 1'b0;
      we_q    <= 1'b0;
      err_q   <= 1'b0;
      size_q  <= SZ_1;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (cpu_req_i) begin
          case (tgt_i)
            TGT_PTR: begin
              err_q   <= 1'b0;
              rdata_q <= cpu_we_i ? '0 : raw_i;
              state_q <= S_RESP;
            end
            TGT_CFG, TGT_IO: begin
              req_q   <= 1'b1;
              io_q    <= (tgt_i == TGT_IO);
              we_q    <= cpu_we_i;
              size_q  <= cpu_size_i;
              addr_q  <= (tgt_i == TGT_IO) ? {{(32-IO_AW){1'b0}}, io_addr}
                                           : {work_i[31:2], k_i};
              wdata_q <= (tgt_i == TGT_IO) ? swap_sz(cpu_wdata_i, cpu_size_i)
                                           : (cpu_wdata_i & size_mask(cpu_size_i));
              state_q <= S_WAIT;
            end
            default: begin
              err_q   <= 1'b1;
              rdata_q <= '0;
              state_q <= S_RESP;
            end
          endcase
        end
        S_WAIT: if (ds_ack_i) begin
          req_q   <= 1'b0;
          err_q   <= ds_err_i;
          rdata_q <= (ds_err_i || we_q) ? '0 : rd_fmt;
          state_q <= S_RESP;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cpu_ack_o   = (state_q == S_RESP);
  assign cpu_err_o   = err_q;
  assign cpu_rdata_o = rdata_q;
  assign ds_req_o    = req_q;
  assign ds_io_o     = io_q;
  assign ds_we_o     = we_q;
  assign ds_addr_o   = addr_q;
  assign ds_size_o   = size_q;
  assign ds_wdata_o  = wdata_q;

  p_req_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_req_o && !ds_ack_i |=> ds_req_o && $stable(ds_addr_o) && $stable(ds_wdata_o) && $stable(ds_size_o));
  p_no_early_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_req_o |-> !cpu_ack_o);
  p_ack_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |=> !cpu_ack_o);
  p_reject_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && tgt_i == TGT_NONE |=> !ds_req_o && cpu_ack_o && cpu_err_o);
  p_err_reads_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o && cpu_err_o |-> cpu_rdata_o == 32'h0);
  p_ds_err_passed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_req_o && ds_ack_i && ds_err_i |=> cpu_ack_o && cpu_err_o);
  p_io_addr_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_req_o && ds_io_o |-> ds_addr_o[31:IO_AW] == '0);
  p_io_word_align_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_req_o && ds_io_o && ds_size_o == SZ_4 |-> ds_addr_o[1:0] == 2'd0);
  p_cfg_base_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_req_o && !ds_io_o |-> ds_addr_o[31:2] == work_i[31:2]);
endmodule

// File: rtl/pci_indirect_port.sv
module pci_indirect_port
  import pcib_pkg::*;
#(
  parameter int OFF_W   = 4,
  parameter int PTR_OFF = 0,
  parameter int CFG_OFF = 4,
  parameter int IO_OFF  = 8,
  parameter int IO_AW   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_req_i,
  input  logic             cpu_we_i,
  input  logic [OFF_W-1:0] cpu_off_i,
  input  logic [1:0]       cpu_size_i,
  input  logic [31:0]      cpu_wdata_i,
  output logic             cpu_ack_o,
  output logic             cpu_err_o,
  output logic [31:0]      cpu_rdata_o,
  output logic             ds_req_o,
  output logic             ds_io_o,
  output logic             ds_we_o,
  output logic [31:0]      ds_addr_o,
  output logic [1:0]       ds_size_o,
  output logic [31:0]      ds_wdata_o,
  input  logic             ds_ack_i,
  input  logic             ds_err_i,
  input  logic [31:0]      ds_rdata_i
);
  tgt_e        tgt;
  logic [1:0]  k;
  logic        ptr_we;
  logic [31:0] ptr_raw, ptr_work;

  pcib_decode #(
    .OFF_W(OFF_W), .PTR_OFF(PTR_OFF), .CFG_OFF(CFG_OFF), .IO_OFF(IO_OFF)
  ) u_dec (
    .off_i(cpu_off_i), .size_i(cpu_size_i), .tgt_o(tgt), .k_o(k)
  );

  pcib_ptr_reg u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(ptr_we), .wdata_i(cpu_wdata_i),
    .raw_o(ptr_raw), .work_o(ptr_work)
  );

  pcib_ctrl #(.IO_AW(IO_AW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_size_i(cpu_size_i),
    .cpu_wdata_i(cpu_wdata_i), .tgt_i(tgt), .k_i(k),
    .raw_i(ptr_raw), .work_i(ptr_work), .ptr_we_o(ptr_we),
    .cpu_ack_o(cpu_ack_o), .cpu_err_o(cpu_err_o), .cpu_rdata_o(cpu_rdata_o),
    .ds_req_o(ds_req_o), .ds_io_o(ds_io_o), .ds_we_o(ds_we_o),
    .ds_addr_o(ds_addr_o), .ds_size_o(ds_size_o), .ds_wdata_o(ds_wdata_o),
    .ds_ack_i(ds_ack_i), .ds_err_i(ds_err_i), .ds_rdata_i(ds_rdata_i)
  );

  // pointer only changes on an accepted 4-byte write
  p_ptr_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_req_i && cpu_we_i && cpu_size_i == SZ_4 && cpu_off_i == OFF_W'(PTR_OFF)) |=> $stable(ptr_raw));
endmodule

// File: tb/tb_pci_indirect_port.sv
`timescale 1ns/1ps
module tb_pci_indirect_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [3:0]  cpu_off = '0;
  logic [1:0]  cpu_size = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ack, cpu_err;
  logic [31:0] cpu_rdata;
  logic        ds_req, ds_io, ds_we;
  logic [31:0] ds_addr, ds_wdata;
  logic [1:0]  ds_size;
  logic        ds_ack = 1'b0, ds_err = 1'b0;
  logic [31:0] ds_rdata = '0;

  int n_run = 0, n_fail = 0;

  // captured per access
  logic        g_err, g_io, g_we;
  logic [31:0] g_rd, g_addr, g_wd;
  logic [1:0]  g_sz;
  int          g_nreq;
  logic        g_early;

  always #2.5 clk = ~clk;

  pci_indirect_port dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_off_i(cpu_off),
    .cpu_size_i(cpu_size), .cpu_wdata_i(cpu_wdata),
    .cpu_ack_o(cpu_ack), .cpu_err_o(cpu_err), .cpu_rdata_o(cpu_rdata),
    .ds_req_o(ds_req), .ds_io_o(ds_io), .ds_we_o(ds_we), .ds_addr_o(ds_addr),
    .ds_size_o(ds_size), .ds_wdata_o(ds_wdata),
    .ds_ack_i(ds_ack), .ds_err_i(ds_err), .ds_rdata_i(ds_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [3:0] off, input logic [1:0] sz,
                        input logic [31:0] wd, input int lat, input logic derr,
                        input logic [31:0] drd);
    int wcnt = 0, guard = 0;
    logic seen = 1'b0, done = 1'b0, answered = 1'b0;
    g_nreq = 0; g_early = 1'b0;
    g_err = 1'b0; g_rd = '0; g_addr = '0; g_wd = '0; g_sz = '0; g_io = 1'b0; g_we = 1'b0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_off = off; cpu_size = sz; cpu_wdata = wd;
    while (!done) begin
      @(negedge clk);
      guard++;
      if (ds_ack) begin
        ds_ack = 1'b0; ds_err = 1'b0; ds_rdata = '0; answered = 1'b1;
      end else if (ds_req) begin
        if (!seen || answered) begin
          seen = 1'b1; answered = 1'b0; g_nreq++;
          g_addr = ds_addr; g_wd = ds_wdata; g_sz = ds_size; g_io = ds_io; g_we = ds_we;
        end
        if (wcnt >= lat) begin
          ds_ack = 1'b1; ds_err = derr; ds_rdata = drd;
        end else wcnt++;
      end
      if (cpu_ack) begin
        if (ds_req) g_early = 1'b1;
        g_err = cpu_err; g_rd = cpu_rdata;
        cpu_req = 1'b0;
        done = 1'b1;
      end
      if (guard > 200) begin
        n_run++; n_fail++;
        $display("FAIL R9: access hung, actual no ack expected ack");
        cpu_req = 1'b0; ds_ack = 1'b0;
        done = 1'b1;
      end
    end
  endtask

  task automatic t_reset;
    check("R10 ds_req after reset", {31'b0, ds_req}, 32'h0);
    check("R10 cpu_ack after reset", {31'b0, cpu_ack}, 32'h0);
    access(1'b0, 4'h0, 2'd2, 0, 0, 1'b0, 0);
    check("R1 pointer reset value", g_rd, 32'h0);
  endtask

  task automatic t_ptr;
    access(1'b1, 4'h0, 2'd2, 32'h1234_567b, 0, 1'b0, 0);
    check("R1 pointer write err", {31'b0, g_err}, 32'h0);
    check("R1 pointer write no ds", g_nreq, 0);
    access(1'b0, 4'h0, 2'd2, 0, 0, 1'b0, 0);
    check("R1 pointer readback incl low bits", g_rd, 32'h1234_567b);
    access(1'b1, 4'h0, 2'd1, 32'hdead_beef, 0, 1'b0, 0);
    check("R8 short pointer write err", {31'b0, g_err}, 32'h1);
    check("R8 short pointer write no ds", g_nreq, 0);
    access(1'b0, 4'h0, 2'd2, 0, 0, 1'b0, 0);
    check("R8 pointer unchanged after reject", g_rd, 32'h1234_567b);
  endtask

  task automatic t_cfg;
    access(1'b0, 4'h4, 2'd2, 0, 0, 1'b0, 32'ha1b2_c3d4);
    check("R2 cfg addr k=0", g_addr, 32'h1234_5678);
    check("R2 cfg space flag", {31'b0, g_io}, 32'h0);
    check("R6 cfg read unswapped", g_rd, 32'ha1b2_c3d4);
    check("R9 one ds request", g_nreq, 1);
    access(1'b1, 4'h7, 2'd0, 32'hffff_ffee, 0, 1'b0, 0);
    check("R2 cfg addr k=3", g_addr, 32'h1234_567b);
    check("R6 cfg write masked", g_wd, 32'h0000_00ee);
    check("R5 cfg byte write ok", {31'b0, g_err}, 32'h0);
    access(1'b0, 4'h6, 2'd1, 0, 0, 1'b0, 32'hffff_1234);
    check("R6 cfg halfword masked not swapped", g_rd, 32'h0000_1234);
    check("R5 cfg halfword size code", {30'b0, g_sz}, 32'h1);
  endtask

  task automatic t_cfg_reject;
    access(1'b0, 4'h6, 2'd2, 0, 0, 1'b0, 32'h1111_1111);
    check("R5 cfg word at k=2 rejected", {31'b0, g_err}, 32'h1);
    check("R8 cfg reject no ds", g_nreq, 0);
    check("R8 cfg reject reads zero", g_rd, 32'h0);
    access(1'b1, 4'h7, 2'd1, 32'h55, 0, 1'b0, 0);
    check("R5 cfg half at k=3 rejected", {31'b0, g_err}, 32'h1);
    access(1'b0, 4'h4, 2'd3, 0, 0, 1'b0, 0);
    check("R5 size code 3 rejected", {31'b0, g_err}, 32'h1);
    access(1'b1, 4'hc, 2'd2, 32'h1, 0, 1'b0, 0);
    check("R5 unmapped offset rejected", {31'b0, g_err}, 32'h1);
    check("R8 unmapped no ds", g_nreq, 0);
  endtask

  task automatic t_io;
    access(1'b1, 4'h0, 2'd2, 32'habcd_1236, 0, 1'b0, 0);
    access(1'b0, 4'h8, 2'd2, 0, 0, 1'b0, 32'h1122_3344);
    check("R3 io addr truncated", g_addr, 32'h0000_1234);
    check("R3 io space flag", {31'b0, g_io}, 32'h1);
    check("R6 io word read swapped", g_rd, 32'h4433_2211);
    access(1'b1, 4'ha, 2'd1, 32'h0000_beef, 0, 1'b0, 0);
    check("R3 io addr k=2", g_addr, 32'h0000_1236);
    check("R6 io half write swapped", g_wd, 32'h0000_efbe);
    check("R4 io half at 2 ok", {31'b0, g_err}, 32'h0);
    access(1'b1, 4'h9, 2'd0, 32'h0000_335a, 0, 1'b0, 0);
    check("R3 io addr k=1", g_addr, 32'h0000_1235);
    check("R6 io byte write", g_wd, 32'h0000_005a);
    check("R4 io byte at 1 ok", {31'b0, g_we}, 32'h1);
    access(1'b0, 4'hb, 2'd0, 0, 0, 1'b0, 32'hffff_ff77);
    check("R4 io byte at 3 read", g_rd, 32'h0000_0077);
  endtask

  task automatic t_io_reject;
    access(1'b0, 4'h9, 2'd1, 0, 0, 1'b0, 0);
    check("R4 io half at 1 rejected", {31'b0, g_err}, 32'h1);
    access(1'b0, 4'ha, 2'd2, 0, 0, 1'b0, 0);
    check("R4 io word at 2 rejected", {31'b0, g_err}, 32'h1);
    access(1'b1, 4'hb, 2'd1, 32'h1, 0, 1'b0, 0);
    check("R4 io half at 3 rejected", {31'b0, g_err}, 32'h1);
    check("R8 io reject no ds", g_nreq, 0);
  endtask

  task automatic t_err_latency;
    access(1'b0, 4'h8, 2'd2, 0, 2, 1'b1, 32'hcafe_f00d);
    check("R7 ds error returned", {31'b0, g_err}, 32'h1);
    check("R7 error reads zero", g_rd, 32'h0);
    access(1'b0, 4'h4, 2'd2, 0, 6, 1'b0, 32'h0bad_cafe);
    check("R9 slow response single request", g_nreq, 1);
    check("R9 no ack while pending", {31'b0, g_early}, 32'h0);
    check("R9 slow read data", g_rd, 32'h0bad_cafe);
    check("R7 slow ok status", {31'b0, g_err}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ptr();
    t_cfg();
    t_cfg_reject();
    t_io();
    t_io_reject();
    t_err_latency();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule